// File: doc/BRIEF.md
# Bridge I/O and Legacy Display Forwarding Decoder

This block decides, for each transaction seen by a two-port bus bridge, whether the bridge claims it and carries it to the other side. A transaction on the primary (upstream) side that falls inside the programmed I/O window goes downstream. A transaction on the secondary (downstream) side that falls outside that window goes upstream. The decision is registered, so both forward flags appear one clock after the address is presented with its valid strobe.

Two mode bits change the decode, and both sit in a small control register that clears on reset. The legacy-alias mode removes part of the I/O window. In the first 64KB of I/O space, the upper 768 bytes of every 1KB block are taken out of the window. Primary accesses to those bytes stop going downstream, and secondary accesses to them go upstream instead. The legacy-display mode forwards the old display memory and I/O ranges downstream whatever the window holds.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: With alias mode clear, a valid primary I/O request whose address satisfies io_base <= address <= io_limit sets fwd_down. Primary I/O outside that range, and primary memory requests outside the display range, set neither flag.
- R2: When io_base > io_limit the window is empty. No primary I/O request is forwarded downstream through the window, and every secondary I/O request is forwarded upstream unless R7 applies.
- R3: With alias mode set, a primary I/O request that is inside the window, below 0x10000, and has address bits [9:8] not equal to 00 does not set fwd_down. In-window addresses with bits [9:8] equal to 00 are still forwarded.
- R4: With alias mode set, a secondary I/O request that is inside the window, below 0x10000, and has bits [9:8] not equal to 00 sets fwd_up. Other in-window secondary requests set no flag, and out-of-window secondary I/O requests set fwd_up.
- R5: The alias filtering of R3 and R4 applies only below 0x10000. At or above that address, the window decision is the same as with alias mode clear.
- R6: With display mode set, a primary request is forwarded downstream regardless of the window or alias mode when it is either (a) a memory request in 0xA0000 to 0xBFFFF, or (b) an I/O request whose low 10 address bits are in 0x3B0 to 0x3BB or 0x3C0 to 0x3DF. With display mode clear, these ranges get no special treatment.
- R7: With display mode set, a secondary request that hits a display range (memory or I/O, as in R6) is not forwarded upstream. Secondary memory requests are never forwarded upstream.
- R8: Both mode bits are 0 after reset. A cycle with cfg_wr high loads cfg_isa and cfg_vga. The request presented in that same cycle is decoded with the old mode values.
- R9: Both flags are registered: they reflect the request presented before the previous rising edge. A cycle with req_valid low yields both flags low.
- R10: fwd_down and fwd_up are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_from_sec | input | 1 | 1 = request originates on the secondary side |
| req_addr | input | ADDR_W | Request address |
| io_base | input | ADDR_W | Lowest address of the I/O window |
| io_limit | input | ADDR_W | Highest address of the I/O window |
| cfg_wr | input | 1 | Load the mode register |
| cfg_isa | input | 1 | New value of the alias-filter mode bit |
| cfg_vga | input | 1 | New value of the display-forwarding mode bit |
| mode_isa | output | 1 | Current alias-filter mode bit |
| mode_vga | output | 1 | Current display-forwarding mode bit |
| fwd_down | output | 1 | Forward the previous request primary to secondary |
| fwd_up | output | 1 | Forward the previous request secondary to primary |

## Verification
Two functions can meet in one cycle: a write to the mode register and the decoding of a request. The bench provokes this by writing new mode bits on the same cycle that it presents an in-window address whose decision depends on them. It then judges the outcome against a reference model that applies the old mode to that request and the new mode to the next one. A second overlap is the display override and the alias filter acting on one address, for example I/O 0x3C0 inside the window with both modes set. There the model expects the override to win.

// File: rtl/fwd_dec_pkg.sv
package fwd_dec_pkg;

    localparam int ALIAS_BITS   = 10;  // legacy I/O decodes on 10 bits
    localparam int LOW_IO_BITS  = 16;  // alias filter limited to first 64KB

    typedef struct packed {
        logic isa;
        logic vga;
    } mode_t;

    typedef struct packed {
        logic down;
        logic up;
    } route_t;

    // Offset inside a 1KB block lies in its upper 768 bytes.
    function automatic logic alias_high(input logic [ALIAS_BITS-1:0] a);
        return a[9:8] != 2'b00;
    endfunction

    // Legacy display I/O ports, 10-bit decode.
    function automatic logic vga_io_hit(input logic [ALIAS_BITS-1:0] a);
        return ((a >= 10'h3B0) && (a <= 10'h3BB)) ||
               ((a >= 10'h3C0) && (a <= 10'h3DF));
    endfunction

endpackage

// File: rtl/fwd_mode_reg.sv
module fwd_mode_reg
    import fwd_dec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  mode_t wdata,
    output mode_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/fwd_io_window.sv
module fwd_io_window
    import fwd_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic              isa_en,
    output logic              in_win,
    output logic              isa_block
);
    logic low_space;

    generate
        if (ADDR_W > LOW_IO_BITS) begin : g_wide
            assign low_space = ~|addr[ADDR_W-1:LOW_IO_BITS];
        end else begin : g_narrow
            assign low_space = 1'b1;
        end
    endgenerate

    always_comb begin
        in_win    = (base <= limit) && (addr >= base) && (addr <= limit);
        isa_block = isa_en && in_win && low_space && alias_high(addr[ALIAS_BITS-1:0]);
    end
endmodule

// File: rtl/fwd_vga_match.sv
module fwd_vga_match
    import fwd_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:17]     addr_hi,
    input  logic [ALIAS_BITS-1:0]  addr_lo,
    input  logic                   is_io,
    output logic                   hit
);
    logic upper_zero;

    generate
        if (ADDR_W > 20) begin : g_upper
            assign upper_zero = ~|addr_hi[ADDR_W-1:20];
        end else begin : g_none
            assign upper_zero = 1'b1;
        end
    endgenerate

    logic mem_hit;
    // 0xA0000..0xBFFFF: bits [19:17] = 101
    assign mem_hit = upper_zero && (addr_hi[19:17] == 3'b101);
    assign hit     = is_io ? vga_io_hit(addr_lo) : mem_hit;
endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
    import fwd_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_io,
    input  logic              req_from_sec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] io_limit,
    input  logic              cfg_wr,
    input  logic              cfg_isa,
    input  logic              cfg_vga,
    output logic              mode_isa,
    output logic              mode_vga,
    output logic              fwd_down,
    output logic              fwd_up
);
    mode_t  mode_q;
    mode_t  mode_wdata;
    logic   in_win, isa_block, vga_hit, vga_take;
    route_t route_d, route_q;

    assign mode_wdata = '{isa: cfg_isa, vga: cfg_vga};

    fwd_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (mode_wdata),
        .q     (mode_q)
    );

    fwd_io_window #(.ADDR_W(ADDR_W)) u_win (
        .addr      (req_addr),
        .base      (io_base),
        .limit     (io_limit),
        .isa_en    (mode_q.isa),
        .in_win    (in_win),
        .isa_block (isa_block)
    );

    fwd_vga_match #(.ADDR_W(ADDR_W)) u_vga (
        .addr_hi (req_addr[ADDR_W-1:17]),
        .addr_lo (req_addr[ALIAS_BITS-1:0]),
        .is_io   (req_is_io),
        .hit     (vga_hit)
    );

    assign vga_take = mode_q.vga && vga_hit;

    always_comb begin
        route_d = '0;
        if (req_valid) begin
            if (!req_from_sec) begin
                route_d.down = (req_is_io && in_win && !isa_block) || vga_take;
            end else begin
                route_d.up = req_is_io && (!in_win || isa_block) && !vga_take;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) route_q <= '0;
        else     route_q <= route_d;
    end

    assign fwd_down = route_q.down;
    assign fwd_up   = route_q.up;
    assign mode_isa = mode_q.isa;
    assign mode_vga = mode_q.vga;

    // R10: the two forward flags exclude each other
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fwd_down && fwd_up));

    // R8: reset clears modes and flags
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!mode_isa && !mode_vga && !fwd_down && !fwd_up));

    // R9: no request, no forward
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!fwd_down && !fwd_up));

    // R6: display override wins on the primary side
    a_r6_vga_override: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_from_sec && mode_vga && vga_hit) |=> fwd_down);

    // R7: display ranges on the secondary side never go upstream
    a_r7_vga_no_up: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_from_sec && mode_vga && vga_hit) |=> !fwd_up);

    // R3: alias-blocked primary address not sent downstream without override
    a_r3_alias_block: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_from_sec && isa_block && !vga_take) |=> !fwd_down);

    // R8: a register write is visible on the next cycle
    a_r8_mode_load: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (mode_isa == $past(cfg_isa) && mode_vga == $past(cfg_vga)));
endmodule

// File: tb/test_bridge_fwd_decoder.sv
module test_bridge_fwd_decoder;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          req_valid = 0, req_is_io = 0, req_from_sec = 0;
    logic [AW-1:0] req_addr = '0, io_base = '0, io_limit = '0;
    logic          cfg_wr = 0, cfg_isa = 0, cfg_vga = 0;
    logic          mode_isa, mode_vga, fwd_down, fwd_up;

    bridge_fwd_decoder #(.ADDR_W(AW)) i_bridge_fwd_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_from_sec(req_from_sec), .req_addr(req_addr), .io_base(io_base),
        .io_limit(io_limit), .cfg_wr(cfg_wr), .cfg_isa(cfg_isa), .cfg_vga(cfg_vga),
        .mode_isa(mode_isa), .mode_vga(mode_vga), .fwd_down(fwd_down), .fwd_up(fwd_up)
    );

    int    n_cmp = 0, n_bad = 0;
    logic  exp_down = 0, exp_up = 0, m_isa = 0, m_vga = 0;
    string exp_tag = "R8";

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference decision
    task automatic model(input logic v, io, sec, input longint a, b, l,
                         input logic isa, vga, output logic d, output logic u);
        bit win, blk, vh;
        longint off;
        off = a % 1024;
        win = (b <= l) && (a >= b) && (a <= l);
        blk = isa && win && (a < 65536) && (off >= 256);
        if (io) vh = (off >= 944 && off <= 955) || (off >= 960 && off <= 991);
        else    vh = (a >= 655360) && (a <= 786431);
        d = v && !sec && ((io && win && !blk) || (vga && vh));
        u = v && sec && io && (!win || blk) && !(vga && vh);
    endtask

    task automatic step(input string tag, input logic v, input logic io, input logic sec,
                        input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] l,
                        input logic wr = 0, input logic wi = 0, input logic wv = 0);
        @(negedge clk);
        chk(exp_tag, "fwd_down", fwd_down, exp_down);
        chk(exp_tag, "fwd_up",   fwd_up,   exp_up);
        chk("R8", "mode_isa", mode_isa, m_isa);
        chk("R8", "mode_vga", mode_vga, m_vga);
        chk("R10", "exclusive", fwd_down & fwd_up, 1'b0);
        req_valid = v; req_is_io = io; req_from_sec = sec; req_addr = a;
        io_base = b; io_limit = l; cfg_wr = wr; cfg_isa = wi; cfg_vga = wv;
        model(v, io, sec, longint'(a), longint'(b), longint'(l), m_isa, m_vga, exp_down, exp_up);
        exp_tag = tag;
        if (wr) begin m_isa = wi; m_vga = wv; end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8", "reset mode_isa", mode_isa, 1'b0);
        chk("R8", "reset mode_vga", mode_vga, 1'b0);
        chk("R9", "reset fwd_down", fwd_down, 1'b0);
        chk("R9", "reset fwd_up",   fwd_up,   1'b0);
        rst = 1'b0;

        // R1: inclusive window, alias mode clear
        step("R1", 1, 1, 0, 32'h1000, 32'h1000, 32'h1FFF);
        step("R1", 1, 1, 0, 32'h1FFF, 32'h1000, 32'h1FFF);
        step("R1", 1, 1, 0, 32'h0FFF, 32'h1000, 32'h1FFF);
        step("R1", 1, 1, 0, 32'h2000, 32'h1000, 32'h1FFF);
        step("R1", 1, 1, 0, 32'h1100, 32'h1000, 32'h1FFF);
        step("R1", 1, 0, 0, 32'h1500, 32'h1000, 32'h1FFF);
        // R9: no valid, no forward
        step("R9", 0, 1, 0, 32'h1500, 32'h1000, 32'h1FFF);
        // R2: empty window
        step("R2", 1, 1, 0, 32'h2800, 32'h3000, 32'h2000);
        step("R2", 1, 1, 1, 32'h2800, 32'h3000, 32'h2000);
        // R8: write alias mode with an alias-sensitive request in the same cycle
        step("R8", 1, 1, 0, 32'h1100, 32'h1000, 32'h1FFF, 1, 1, 0);
        // R3: alias filtering downstream
        step("R3", 1, 1, 0, 32'h1100, 32'h1000, 32'h1FFF);
        step("R3", 1, 1, 0, 32'h1000, 32'h1000, 32'h1FFF);
        step("R3", 1, 1, 0, 32'h10FF, 32'h1000, 32'h1FFF);
        step("R3", 1, 1, 0, 32'h1400, 32'h1000, 32'h1FFF);
        step("R3", 1, 1, 0, 32'h17FF, 32'h1000, 32'h1FFF);
        // R4: alias redirect upstream
        step("R4", 1, 1, 1, 32'h1100, 32'h1000, 32'h1FFF);
        step("R4", 1, 1, 1, 32'h1000, 32'h1000, 32'h1FFF);
        step("R4", 1, 1, 1, 32'h5000, 32'h1000, 32'h1FFF);
        // R5: filtering limited to first 64KB
        step("R5", 1, 1, 0, 32'hFF00,  32'hF000, 32'h10FFF);
        step("R5", 1, 1, 0, 32'h10300, 32'hF000, 32'h10FFF);
        step("R5", 1, 1, 1, 32'h10300, 32'hF000, 32'h10FFF);
        step("R5", 1, 1, 1, 32'hFF00,  32'hF000, 32'h10FFF);
        // R6: display override, window disabled, alias on
        step("R8", 0, 0, 0, 32'h0, 32'h3000, 32'h2000, 1, 1, 1);
        step("R6", 1, 0, 0, 32'hA0000, 32'h3000, 32'h2000);
        step("R6", 1, 0, 0, 32'hBFFFF, 32'h3000, 32'h2000);
        step("R6", 1, 0, 0, 32'h9FFFF, 32'h3000, 32'h2000);
        step("R6", 1, 0, 0, 32'hC0000, 32'h3000, 32'h2000);
        step("R6", 1, 0, 0, 32'h100A0000, 32'h3000, 32'h2000);
        step("R6", 1, 1, 0, 32'h3B0, 32'h3000, 32'h2000);
        step("R6", 1, 1, 0, 32'h3BB, 32'h3000, 32'h2000);
        step("R6", 1, 1, 0, 32'h3BC, 32'h3000, 32'h2000);
        step("R6", 1, 1, 0, 32'h3DF, 32'h3000, 32'h2000);
        step("R6", 1, 1, 0, 32'h3E0, 32'h3000, 32'h2000);
        step("R6", 1, 1, 0, 32'h7C0, 32'h3000, 32'h2000);
        // overlap: display and alias on an in-window address
        step("R6", 1, 1, 0, 32'h3C0, 32'h0000, 32'hFFFF);
        // R7: display ranges stay on the secondary side
        step("R7", 1, 1, 1, 32'h3C0, 32'h3000, 32'h2000);
        step("R7", 1, 0, 1, 32'hA0000, 32'h3000, 32'h2000);
        step("R7", 1, 1, 1, 32'h3BC, 32'h3000, 32'h2000);
        // display mode cleared: no override
        step("R8", 0, 0, 0, 32'h0, 32'h3000, 32'h2000, 1, 0, 0);
        step("R6", 1, 0, 0, 32'hA0000, 32'h3000, 32'h2000);
        step("R6", 1, 1, 0, 32'h3C0, 32'h3000, 32'h2000);
        step("R7", 1, 1, 1, 32'h3C0, 32'h3000, 32'h2000);

        // R10: randomized mix
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a, b, l;
            logic wr;
            b  = AW'($urandom_range(0, 32'h1_2000));
            l  = AW'($urandom_range(0, 32'h1_2000));
            a  = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(32'h9_F000, 32'hC_1000))
                                             : AW'($urandom_range(0, 32'h1_2000));
            wr = ($urandom_range(0, 15) == 0);
            step("R10", 1'($urandom), 1'($urandom), 1'($urandom), a, b, l,
                 wr, 1'($urandom), 1'($urandom));
        end
        step("R9", 0, 0, 0, 32'h0, 32'h0, 32'h0);
        step("R9", 0, 0, 0, 32'h0, 32'h0, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule